// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves bytes between channel slots of several serial TDM streams that share one bit clock and an 8 kHz frame. Every input stream is shifted in MSB first. Each completed byte is written into a data memory at the address given by its stream, its channel slot and the parity of the current frame. The channel counter behind that address restarts whenever the frame pulse arrives, and it also restarts on its own after the last slot of the selected rate.

A connection memory holds one entry per output stream and channel. An entry either names an input stream and an input channel, whose byte from the previous frame is then sent, or it is in message mode and supplies the output byte itself. A processor fills the entries through a single write port. Input and output run at the same rate, and the rate is set by a static two-bit field that gives 32, 64, 128 or 256 channels per frame. The number of streams N is a parameter from 1 to 5, because the entries for the N outputs are fetched one per bit clock inside each channel slot.

Top module: `tsi_switch`

## Requirements
- R1: While `rst` is high, and for the first 8 bit clocks after it falls, every bit of `tx_o` is 0.
- R2: `rate_i` values 0, 1, 2 and 3 give 32, 64, 128 and 256 channel slots of 8 bit clocks each. After the last slot a new frame starts with no frame pulse needed.
- R3: If `fp_i` is high in a bit clock, the next bit clock is the first bit of channel 0 of a new frame, whatever the position before it.
- R4: Each input stream is received MSB first. Its byte is committed on the eighth bit clock of its channel slot and is kept for the frame that follows.
- R5: If message mode is off in an entry, output stream k in channel c carries the byte that was received in the previous frame on the named source stream and source channel.
- R6: If message mode is on in an entry, output stream k in channel c carries bits [7:0] of that entry.
- R7: Output channel c is sent MSB first during channel slot c+1. The last channel is sent during slot 0 of the next frame.
- R8: A high `cm_we_i` writes `cm_data_i` into the entry for output stream `cm_stream_i` and channel `cm_chan_i`. Bit [CMW-1] is the message-mode flag, bits [CMW-2:8] are the source stream and bits [7:0] are the source channel or the message byte.
- R9: Output channel 0 of a frame may select the last channel of the previous frame on any stream and gets that byte intact, including when the frame changes by pulse or by wrap in the cycle that commits it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rate_i | input | 2 | Static rate select (0:32, 1:64, 2:128, 3:256 channels) |
| fp_i | input | 1 | Frame pulse, high in the bit clock before a frame starts |
| rx_i | input | N | Serial input streams |
| tx_o | output | N | Serial output streams, registered |
| cm_we_i | input | 1 | Connection memory write strobe |
| cm_stream_i | input | SW | Output stream of the entry being written |
| cm_chan_i | input | 8 | Output channel of the entry being written |
| cm_data_i | input | CMW | Entry value: mode flag, source stream, source channel or message byte |

## Verification
Two things can happen in the same bit clock. The byte of the last input channel is committed, and the frame position restarts with a flip of buffer parity. The next fetch, for output channel 0, must then read that byte from the buffer just retired. To provoke this, entries route output stream 0, channel 0 from the highest stream's last channel. One set of runs places the frame pulse exactly on that commit cycle, and another run leaves the counter to wrap by itself. The byte seen on the output during slot 1 is compared with the byte the bench drove in the previous frame, alongside randomly routed and message-mode channels at all four rates.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int CH_W  = 8;
  localparam int BIT_W = 3;

  // Index of the final channel slot for a rate code (32 << code channels).
  function automatic logic [CH_W-1:0] last_chan(input logic [1:0] rate);
    return CH_W'((32 << rate) - 1);
  endfunction
endpackage

// File: rtl/tsi_frame_ctr.sv
module tsi_frame_ctr
  import tsi_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       rate_i,
  input  logic             fp_i,
  output logic [BIT_W-1:0] bit_idx,
  output logic [CH_W-1:0]  ch_idx,
  output logic             par
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_idx <= '0;
      ch_idx  <= '0;
      par     <= 1'b0;
    end else if (fp_i) begin
      bit_idx <= '0;
      ch_idx  <= '0;
      par     <= ~par;
    end else if (bit_idx == BIT_W'(7)) begin
      bit_idx <= '0;
      if (ch_idx == last_chan(rate_i)) begin
        ch_idx <= '0;
        par    <= ~par;
      end else begin
        ch_idx <= ch_idx + 1'b1;
      end
    end else begin
      bit_idx <= bit_idx + 1'b1;
    end
  end
endmodule

// File: rtl/tsi_sdp_ram.sv
module tsi_sdp_ram #(
  parameter int DW = 8,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tsi_tx_ser.sv
module tsi_tx_ser (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] din,
  output logic       tx
);
  logic [7:0] sr;

  always_ff @(posedge clk) begin
    if (rst)       sr <= '0;
    else if (load) sr <= din;
    else           sr <= {sr[6:0], 1'b0};
  end

  assign tx = sr[7];
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter  int N   = 4,
  localparam int SW  = (N > 1) ? $clog2(N) : 1,
  localparam int CMW = 1 + SW + CH_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      rate_i,
  input  logic            fp_i,
  input  logic [N-1:0]    rx_i,
  output logic [N-1:0]    tx_o,
  input  logic            cm_we_i,
  input  logic [SW-1:0]   cm_stream_i,
  input  logic [CH_W-1:0] cm_chan_i,
  input  logic [CMW-1:0]  cm_data_i
);
  localparam int DM_AW = 1 + CH_W;
  localparam int CM_AW = SW + CH_W;

  logic [BIT_W-1:0] bit_idx;
  logic [CH_W-1:0]  ch_idx;
  logic             par;

  tsi_frame_ctr u_ctr (
    .clk(clk), .rst(rst), .rate_i(rate_i), .fp_i(fp_i),
    .bit_idx(bit_idx), .ch_idx(ch_idx), .par(par)
  );

  // Connection memory: fetched for output stream bit_idx while bit_idx < N.
  logic [CMW-1:0] cm_q;

  tsi_sdp_ram #(.DW(CMW), .AW(CM_AW)) u_cm (
    .clk(clk), .we(cm_we_i), .waddr({cm_stream_i, cm_chan_i}), .wdata(cm_data_i),
    .raddr({bit_idx[SW-1:0], ch_idx}), .rdata(cm_q)
  );

  logic            commit;
  logic [7:0]      dm_rd [N];
  logic [DM_AW-1:0] dm_raddr;

  assign commit   = (bit_idx == BIT_W'(7));
  assign dm_raddr = {~par, cm_q[CH_W-1:0]};

  // One data-memory bank per input stream, halves selected by frame parity.
  for (genvar s = 0; s < N; s++) begin : g_rx
    logic [6:0] shift;

    always_ff @(posedge clk) begin
      if (rst) shift <= '0;
      else     shift <= {shift[5:0], rx_i[s]};
    end

    tsi_sdp_ram #(.DW(8), .AW(DM_AW)) u_dm (
      .clk(clk), .we(commit), .waddr({par, ch_idx}), .wdata({shift, rx_i[s]}),
      .raddr(dm_raddr), .rdata(dm_rd[s])
    );
  end

  // Three-stage fetch: entry read, data read, byte select.
  logic           v1, v2;
  logic [SW-1:0]  i1, i2;
  logic [CMW-1:0] cm2;
  logic [7:0]     tx_next [N];
  logic [SW-1:0]  src_sel;

  assign src_sel = cm2[CMW-2:CH_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= (int'(bit_idx) < N);
      v2 <= v1;
    end
    i1  <= bit_idx[SW-1:0];
    i2  <= i1;
    cm2 <= cm_q;
  end

  always_ff @(posedge clk) begin
    if (v2) tx_next[i2] <= cm2[CMW-1] ? cm2[7:0] : dm_rd[src_sel];
  end

  for (genvar k = 0; k < N; k++) begin : g_tx
    tsi_tx_ser u_ser (
      .clk(clk), .rst(rst), .load(commit), .din(tx_next[k]), .tx(tx_o[k])
    );
  end
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk
  import tsi_pkg::*;
#(
  parameter int N = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       rate_i,
  input logic             fp_i,
  input logic [BIT_W-1:0] bit_idx,
  input logic [CH_W-1:0]  ch_idx,
  input logic             par,
  input logic [N-1:0]     tx_o
);
  // R1: serial outputs are quiet once reset has been seen
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (tx_o == '0));

  // R3: a frame pulse restarts the slot position and flips the buffer
  a_r3_fp_restart: assert property (@(posedge clk) disable iff (rst)
    fp_i |=> (bit_idx == '0 && ch_idx == '0 && par != $past(par)));

  // R2: the final slot of the selected rate rolls into a new frame
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    (!fp_i && bit_idx == BIT_W'(7) && ch_idx == last_chan(rate_i))
      |=> (bit_idx == '0 && ch_idx == '0 && par != $past(par)));

  // R2: the channel position never exceeds the rate's slot count
  a_r2_in_range: assert property (@(posedge clk) disable iff (rst)
    ch_idx <= last_chan(rate_i));

  // R4: bits advance one per clock inside a slot, same channel and buffer
  a_r4_bit_step: assert property (@(posedge clk) disable iff (rst)
    (!fp_i && bit_idx != BIT_W'(7))
      |=> (bit_idx == $past(bit_idx) + BIT_W'(1) && ch_idx == $past(ch_idx)
           && par == $past(par)));
endmodule

bind tsi_switch tsi_switch_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .rate_i(rate_i), .fp_i(fp_i),
  .bit_idx(bit_idx), .ch_idx(ch_idx), .par(par), .tx_o(tx_o)
);

// File: tb/tsi_switch_test.sv
module tsi_switch_test;
  localparam int N   = 4;
  localparam int SW  = 2;
  localparam int CMW = 1 + SW + 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [1:0]     rate_i = '0;
  logic           fp_i = 1'b0;
  logic [N-1:0]   rx_i = '0;
  logic [N-1:0]   tx_o;
  logic           cm_we_i = 1'b0;
  logic [SW-1:0]  cm_stream_i = '0;
  logic [7:0]     cm_chan_i = '0;
  logic [CMW-1:0] cm_data_i = '0;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [7:0] in_bytes [0:4][0:N-1][0:255];
  bit         m_msg [0:N-1][0:255];
  int         m_src [0:N-1][0:255];
  int         m_sch [0:N-1][0:255];
  logic [7:0] m_byte [0:N-1][0:255];

  always #2 clk = ~clk;

  tsi_switch #(.N(N)) uut (
    .clk(clk), .rst(rst), .rate_i(rate_i), .fp_i(fp_i), .rx_i(rx_i), .tx_o(tx_o),
    .cm_we_i(cm_we_i), .cm_stream_i(cm_stream_i), .cm_chan_i(cm_chan_i),
    .cm_data_i(cm_data_i)
  );

  function automatic logic [7:0] exp_byte(int k, int c, int of);
    if (m_msg[k][c]) return m_byte[k][c];
    return in_bytes[of-1][m_src[k][c]][m_sch[k][c]];
  endfunction

  task automatic check(string tag, int rate, int k, int c, int f,
                       logic [7:0] got, logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s rate=%0d stream=%0d ch=%0d frame=%0d got=%h exp=%h",
               tag, rate, k, c, f, got, exp);
    end
  endtask

  task automatic run(int rate, int nf, bit fp_each);
    int nch = 32 << rate;
    int idle = 9 + int'($urandom % 24);
    logic [7:0] got [N];
    @(posedge clk); #1;
    rst = 1'b1; rate_i = 2'(rate); fp_i = 1'b0; rx_i = '0;
    // R8: program every entry through the write port (layout {mode, src stream, low byte})
    for (int k = 0; k < N; k++) begin
      for (int c = 0; c < nch; c++) begin
        m_msg[k][c]  = ($urandom % 4) == 0;
        m_src[k][c]  = int'($urandom % N);
        m_sch[k][c]  = int'($urandom % nch);
        m_byte[k][c] = 8'($urandom);
        if (k == 0 && c == 0) begin m_msg[k][c] = 0; m_src[k][c] = N-1; m_sch[k][c] = nch-1; end
        if (k == N-1 && c == nch-1) begin m_msg[k][c] = 0; m_src[k][c] = 0; m_sch[k][c] = 0; end
        if (k == 1 && c == 0) begin m_msg[k][c] = 1; m_byte[k][c] = 8'hFF; end
        if (k == 2 && c == nch-1) begin m_msg[k][c] = 1; m_byte[k][c] = 8'h00; end
        if (m_msg[k][c]) m_sch[k][c] = int'(m_byte[k][c]);
        cm_we_i = 1'b1; cm_stream_i = SW'(k); cm_chan_i = 8'(c);
        cm_data_i = {m_msg[k][c], SW'(m_src[k][c]), 8'(m_sch[k][c])};
        @(posedge clk); #1;
      end
    end
    cm_we_i = 1'b0;
    for (int f = 0; f < nf; f++)
      for (int s = 0; s < N; s++)
        for (int c = 0; c < nch; c++) in_bytes[f][s][c] = 8'($urandom);
    // hold reset one more cycle so the quiet-output check starts clean
    @(posedge clk); #1;
    rst = 1'b0;
    // Idle stretch; the final idle cycle carries the aligning frame pulse (R3)
    for (int i = 0; i < idle; i++) begin
      rx_i = N'($urandom);
      fp_i = (i == idle - 1);
      #2;
      if (i < 8) check("R1", rate, 0, i, 0, 8'(tx_o), 8'h00);
      @(posedge clk); #1;
    end
    // Frames: nf driven frames plus slot 0 of one more to catch the last channel
    for (int f = 0; f <= nf; f++) begin
      for (int c = 0; c < nch; c++) begin
        if (f == nf && c > 0) break;
        for (int b = 0; b < 8; b++) begin
          for (int s = 0; s < N; s++)
            rx_i[s] = (f < nf) ? in_bytes[f][s][c][7-b] : 1'($urandom);
          fp_i = fp_each && (f < nf) && (c == nch-1) && (b == 7);
          #2;
          for (int k = 0; k < N; k++) got[k] = {got[k][6:0], tx_o[k]};
          if (b == 7) begin
            int oc = (c == 0) ? nch - 1 : c - 1;
            int of = (c == 0) ? f - 1 : f;
            if (of >= 1) begin
              for (int k = 0; k < N; k++) begin
                string tag;
                if (m_msg[k][oc]) tag = "R6";
                else if (oc == 0 && m_sch[k][oc] == nch-1) tag = "R9";
                else tag = fp_each ? "R5" : "R2";
                // R3 R4 R7: frame alignment, MSB-first capture and the
                // one-slot output lag all shape the byte sampled here
                check(tag, rate, k, oc, of, got[k], exp_byte(k, oc, of));
              end
            end
          end
          @(posedge clk); #1;
        end
      end
    end
    fp_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0423));
    run(0, 4, 1'b1);
    run(3, 3, 1'b1);
    run(1, 3, 1'b0);
    run(2, 3, 1'b1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog R1 got=timeout exp=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule